// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital half of an 8-bit successive-approximation converter with a processor bus interface. A host starts a conversion by pulsing the active-low write strobe while the active-low chip select is low. While both are low the block stays cleared. Once either one returns high, the block aligns to an internal phase and then decides the code one bit at a time, starting at the most significant bit. An external analog model sees each trial code on `trial_code` and answers on `cmp_in`.

When the last bit is decided, the code moves into an output holding register and the active-low interrupt falls. A read, with the read strobe and chip select both low, drives the held code onto the tri-state data bus and releases the interrupt. A new start during a conversion abandons that conversion and leaves the holding register untouched.

Tying select and read low and feeding the interrupt back into the write strobe makes the block convert continuously.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, `intr_n` is 1, `bus_drive` is 0 and `trial_code` is 0.
- R2: While `cs_n` and `wr_n` are both low, `trial_code` stays 0 and `intr_n` goes high within 4 clocks and stays high.
- R3: The first trial code, 0x80 (only bit 7 set), appears between 1 and 8 clocks after the release of the start strobe.
- R4: Trials go from bit 7 down to bit 0 and each lasts 8 clocks. During the trial for bit k, `trial_code` holds the bits already decided above k, with bit k set to 1 and the lower bits 0. A `cmp_in` of 1 at the end of the trial keeps bit k, and a 0 clears it.
- R5: `intr_n` falls between 66 and 73 clocks after the start release, and the held code then equals the decided binary code.
- R6: While `cs_n` and `rd_n` are both low, `bus_drive` is 1, `data_bus` carries the held code, and `intr_n` returns high within 4 clocks. A read strobe with `cs_n` high drives nothing and leaves `intr_n` low.
- R7: A start issued during a conversion abandons it. The held code keeps the last completed result until a later conversion completes.
- R8: With `cs_n` and `rd_n` low and `wr_n` fed from `intr_n`, one forced low on the write input makes the block convert repeatedly. Each result follows the input present during that conversion.
- R9: A write strobe while `cs_n` is high starts nothing: `trial_code` stays 0 and `intr_n` keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Start strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| cmp_in | input | 1 | Comparator result: 1 when the input is at or above the trial level |
| trial_code | output | CODE_W | Trial code to the ladder DAC, 0 outside a conversion |
| data_bus | output | CODE_W | Tri-state data output carrying the held code |
| bus_drive | output | 1 | High while the data output is driven |
| intr_n | output | 1 | Conversion-complete interrupt, active low |

## Verification
The bench builds the block with its default values: 8 code bits, 8 clocks per trial, two synchroniser stages and a 2-bit phase counter. With these values the start latency falls at 4 to 7 clocks and completion at 69 to 72 clocks, so both timing windows can be checked edge by edge. A comparator model that answers "input at or above trial" makes the expected result equal to the applied input, including the all-zero and all-one codes. It also gives a known trial-code sequence at every bit position.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

    localparam int DEF_CODE_W      = 8;
    localparam int DEF_TRIAL_CLKS  = 8;
    localparam int DEF_SYNC_STAGES = 2;
    localparam int DEF_PHASE_W     = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_ARM,
        ST_CONV,
        ST_DONE
    } seq_state_e;

    // Bus strobes in asserted-high form after synchronisation
    typedef struct packed {
        logic rd;
        logic wr;
        logic cs;
    } strobe_t;

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) pipe_q <= '0;
                else     pipe_q <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) pipe_q <= '0;
                else     pipe_q <= {pipe_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_ctrl_pkg::*;
#(
    parameter int CODE_W     = DEF_CODE_W,
    parameter int TRIAL_CLKS = DEF_TRIAL_CLKS,
    parameter int PHASE_W    = DEF_PHASE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_hold,
    input  logic              cmp_in,
    output logic [CODE_W-1:0] trial_code,
    output logic [CODE_W-1:0] result,
    output logic              done_pulse
);

    localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
    localparam int CNT_W = (TRIAL_CLKS > 1) ? $clog2(TRIAL_CLKS) : 1;
    localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(CODE_W - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TRIAL_CLKS - 1);

    seq_state_e         state_q;
    logic [PHASE_W-1:0] phase_q;
    logic [IDX_W-1:0]   bit_idx_q;
    logic [CNT_W-1:0]   trial_cnt_q;
    logic [CODE_W-1:0]  sar_q;
    logic [CODE_W-1:0]  bit_mask;

    assign bit_mask = CODE_W'(1) << bit_idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            phase_q     <= '0;
            bit_idx_q   <= TOP_IDX;
            trial_cnt_q <= '0;
            sar_q       <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
            if (start_hold) begin
                state_q     <= ST_HOLD;
                sar_q       <= '0;
                bit_idx_q   <= TOP_IDX;
                trial_cnt_q <= '0;
            end else begin
                case (state_q)
                    ST_HOLD: state_q <= ST_ARM;
                    ST_ARM: begin
                        if (phase_q == '0) begin
                            state_q     <= ST_CONV;
                            bit_idx_q   <= TOP_IDX;
                            trial_cnt_q <= '0;
                        end
                    end
                    ST_CONV: begin
                        if (trial_cnt_q == LAST_CNT) begin
                            trial_cnt_q      <= '0;
                            sar_q[bit_idx_q] <= cmp_in;
                            if (bit_idx_q == '0) state_q   <= ST_DONE;
                            else                 bit_idx_q <= bit_idx_q - 1'b1;
                        end else begin
                            trial_cnt_q <= trial_cnt_q + 1'b1;
                        end
                    end
                    ST_DONE: state_q <= ST_IDLE;
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign trial_code = (state_q == ST_CONV) ? (sar_q | bit_mask) : '0;
    assign result     = sar_q;
    assign done_pulse = (state_q == ST_DONE);

    // R3: a conversion always opens with only the top bit on trial
    a_r3_first_trial_msb: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CONV && $past(state_q) != ST_CONV)
            |-> trial_code == (CODE_W'(1) << (CODE_W - 1)));

    // R4: the trial code does not move inside a bit trial
    a_r4_trial_steady: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CONV && trial_cnt_q != '0) |-> $stable(trial_code));

    // R2: a held start blanks the trial code and cannot complete
    a_r2_hold_blanks: assert property (@(posedge clk) disable iff (rst)
        start_hold |=> (trial_code == '0 && !done_pulse));

endmodule

// File: rtl/sar_bus_if.sv
module sar_bus_if #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_hold,
    input  logic              read_req,
    input  logic              oe_req,
    input  logic              done_pulse,
    input  logic [CODE_W-1:0] result,
    output logic              intr_n,
    output logic              bus_drive,
    output logic [CODE_W-1:0] data_bus
);

    logic              intr_n_q;
    logic [CODE_W-1:0] latch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            intr_n_q <= 1'b1;
            latch_q  <= '0;
        end else begin
            if (done_pulse) latch_q <= result;
            if (start_hold)      intr_n_q <= 1'b1;
            else if (done_pulse) intr_n_q <= 1'b0;
            else if (read_req)   intr_n_q <= 1'b1;
        end
    end

    assign intr_n    = intr_n_q;
    assign bus_drive = oe_req;
    assign data_bus  = oe_req ? latch_q : 'z;

    // R7: the held code changes only on a completed conversion
    a_r7_latch_on_done: assert property (@(posedge clk) disable iff (rst)
        (latch_q != $past(latch_q)) |-> $past(done_pulse));

    // R5: the interrupt only falls after a completion
    a_r5_intr_falls_on_done: assert property (@(posedge clk) disable iff (rst)
        $fell(intr_n) |-> $past(done_pulse));

    // R6: a read with no completion pending releases the interrupt
    a_r6_read_releases: assert property (@(posedge clk) disable iff (rst)
        (read_req && !done_pulse) |=> intr_n);

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_ctrl_pkg::*;
#(
    parameter int CODE_W      = DEF_CODE_W,
    parameter int TRIAL_CLKS  = DEF_TRIAL_CLKS,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES,
    parameter int PHASE_W     = DEF_PHASE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              cmp_in,
    output logic [CODE_W-1:0] trial_code,
    output logic [CODE_W-1:0] data_bus,
    output logic              bus_drive,
    output logic              intr_n
);

    strobe_t           raw_s;
    strobe_t           sync_s;
    logic              start_hold;
    logic              read_req;
    logic              done_pulse;
    logic [CODE_W-1:0] result;

    assign raw_s = '{rd: ~rd_n, wr: ~wr_n, cs: ~cs_n};

    sar_sync #(
        .WIDTH  ($bits(strobe_t)),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_s),
        .q   (sync_s)
    );

    assign start_hold = sync_s.cs & sync_s.wr;
    assign read_req   = sync_s.cs & sync_s.rd;

    sar_seq #(
        .CODE_W     (CODE_W),
        .TRIAL_CLKS (TRIAL_CLKS),
        .PHASE_W    (PHASE_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_hold (start_hold),
        .cmp_in     (cmp_in),
        .trial_code (trial_code),
        .result     (result),
        .done_pulse (done_pulse)
    );

    sar_bus_if #(
        .CODE_W (CODE_W)
    ) u_bus (
        .clk        (clk),
        .rst        (rst),
        .start_hold (start_hold),
        .read_req   (read_req),
        .oe_req     (raw_s.cs & raw_s.rd),
        .done_pulse (done_pulse),
        .result     (result),
        .intr_n     (intr_n),
        .bus_drive  (bus_drive),
        .data_bus   (data_bus)
    );

endmodule

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       wr_drv_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       free_mode = 1'b0;
    logic       kick_n = 1'b1;
    logic [7:0] vin = 8'h00;
    logic       wr_n;
    logic       cmp_in;
    logic [7:0] trial_code;
    logic [7:0] data_bus;
    logic       bus_drive;
    logic       intr_n;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural comparator: 1 when the input is at or above the trial level
    assign cmp_in = (vin >= trial_code);
    assign wr_n   = free_mode ? (intr_n & kick_n) : wr_drv_n;

    sar_adc_ctrl uut (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .wr_n       (wr_n),
        .rd_n       (rd_n),
        .cmp_in     (cmp_in),
        .trial_code (trial_code),
        .data_bus   (data_bus),
        .bus_drive  (bus_drive),
        .intr_n     (intr_n)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic t_reset();
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(1);
        check(intr_n == 1'b1, "R1 intr_n after reset", intr_n, 1);
        check(bus_drive == 1'b0, "R1 bus_drive after reset", bus_drive, 0);
        check(trial_code == 8'h00, "R1 trial_code after reset", trial_code, 0);
    endtask

    // start pulse, then watch latency, trial codes and completion time
    task automatic run_conv(input logic [7:0] v, input bit chk_trials);
        int lat = -1;
        int done_at = -1;
        vin = v;
        @(negedge clk);
        cs_n = 1'b0;
        wr_drv_n = 1'b0;
        tick(3);
        wr_drv_n = 1'b1;
        for (int c = 1; c <= 200; c++) begin
            tick(1);
            if (lat < 0 && trial_code == 8'h80) lat = c;
            if (chk_trials && lat >= 0 && ((c - lat) % 8) == 3 && ((c - lat) / 8) < 8) begin
                int k = 7 - ((c - lat) / 8);
                int hi = 8'hFF & ~((1 << (k + 1)) - 1);
                int exp = (int'(v) & hi) | (1 << k);
                check(trial_code == 8'(exp), "R4 trial code", trial_code, exp);
            end
            if (!intr_n) begin
                done_at = c;
                break;
            end
        end
        cs_n = 1'b1;
        check(lat >= 1 && lat <= 8, "R3 start latency", lat, 8);
        check(done_at >= 66 && done_at <= 73, "R5 completion time", done_at, 73);
    endtask

    task automatic do_read(input logic [7:0] exp, input string what);
        @(negedge clk);
        cs_n = 1'b0;
        rd_n = 1'b0;
        tick(4);
        check(bus_drive == 1'b1, {what, " bus driven"}, bus_drive, 1);
        check(data_bus == exp, {what, " data"}, data_bus, exp);
        check(intr_n == 1'b1, {what, " intr released"}, intr_n, 1);
        rd_n = 1'b1;
        cs_n = 1'b1;
        tick(1);
        check(bus_drive == 1'b0, {what, " bus released"}, bus_drive, 0);
    endtask

    task automatic wait_intr_low(output int n);
        n = -1;
        for (int c = 1; c <= 300; c++) begin
            tick(1);
            if (!intr_n) begin
                n = c;
                break;
            end
        end
    endtask

    task automatic t_basic();
        run_conv(8'hA5, 1'b1);
        do_read(8'hA5, "R6 R5 read A5");
        run_conv(8'h00, 1'b0);
        do_read(8'h00, "R5 read 00");
        run_conv(8'hFF, 1'b1);
        do_read(8'hFF, "R5 read FF");
    endtask

    task automatic t_ignored();
        run_conv(8'h3C, 1'b0);
        // R9: write with select high
        @(negedge clk);
        cs_n = 1'b1;
        wr_drv_n = 1'b0;
        tick(5);
        wr_drv_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick(5);
            check(trial_code == 8'h00, "R9 no trial after deselected write", trial_code, 0);
        end
        check(intr_n == 1'b0, "R9 intr kept low", intr_n, 0);
        // R6: read strobe with select high
        rd_n = 1'b0;
        tick(4);
        check(bus_drive == 1'b0, "R6 no drive without select", bus_drive, 0);
        check(intr_n == 1'b0, "R6 intr not cleared without select", intr_n, 0);
        rd_n = 1'b1;
        do_read(8'h3C, "R6 read 3C");
    endtask

    task automatic t_hold();
        int n;
        run_conv(8'h66, 1'b0);
        @(negedge clk);
        cs_n = 1'b0;
        wr_drv_n = 1'b0;
        for (int i = 0; i < 5; i++) begin
            tick(5);
            check(trial_code == 8'h00, "R2 trial blank while held", trial_code, 0);
            check(intr_n == 1'b1, "R2 intr high while held", intr_n, 1);
        end
        wr_drv_n = 1'b1;
        wait_intr_low(n);
        cs_n = 1'b1;
        check(n >= 66 && n <= 73, "R2 conversion after hold release", n, 73);
        do_read(8'h66, "R2 read 66");
    endtask

    task automatic t_abort();
        int n;
        vin = 8'hC3;
        @(negedge clk);
        cs_n = 1'b0;
        wr_drv_n = 1'b0;
        tick(3);
        wr_drv_n = 1'b1;
        tick(30);
        wr_drv_n = 1'b0;
        tick(3);
        wr_drv_n = 1'b1;
        tick(10);
        cs_n = 1'b1;
        check(intr_n == 1'b1, "R7 no completion after abort", intr_n, 1);
        do_read(8'h66, "R7 old result kept");
        wait_intr_low(n);
        check(n > 0, "R7 restarted conversion completes", n, 1);
        do_read(8'hC3, "R7 new result");
    endtask

    task automatic t_free();
        int n1;
        int n2;
        int n3;
        vin = 8'h5A;
        @(negedge clk);
        cs_n = 1'b0;
        rd_n = 1'b0;
        free_mode = 1'b1;
        kick_n = 1'b0;
        tick(3);
        kick_n = 1'b1;
        wait_intr_low(n1);
        check(n1 > 0, "R8 first free-running completion", n1, 1);
        check(data_bus == 8'h5A, "R8 first free-running result", data_bus, 8'h5A);
        vin = 8'h0F;
        wait_intr_low(n2);
        check(n2 > 0 && n2 <= 80, "R8 second completion interval", n2, 80);
        check(data_bus == 8'h0F, "R8 second free-running result", data_bus, 8'h0F);
        wait_intr_low(n3);
        check(n3 > 0 && n3 <= 80, "R8 third completion interval", n3, 80);
        free_mode = 1'b0;
        rd_n = 1'b1;
        cs_n = 1'b1;
        tick(2);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_ignored();
        t_hold();
        t_abort();
        t_free();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule